// File: doc/BRIEF.md
# Two-Wire Register Slave for a Dual-Axis Sensor

This block is the serial front end of a two-axis motion sensor. It watches the SCL and SDA lines of a standard I2C bus, oversampled on the system clock, and acts as a slave. It recognises START and STOP conditions, matches the address byte, and pulls SDA low through an open-drain enable to acknowledge bytes and to send read data. The master sees one writable control byte and a small read window that holds the X-axis, Y-axis and temperature samples. The sample words come in on parallel inputs from the sensor interface. The control bits go out as power-down, self-test, bandgap-test and temperature-select levels.

A write transfer gives a register address byte and can then give data bytes. A read transfer returns bytes from an internal pointer. The pointer advances by itself after every data byte and wraps at the end of the map. At the moment a read address matches, the block captures all sample words. Every byte of that read then comes from one consistent set of samples.

The state machine has six states. S_IDLE waits for START. S_GET_BYTE shifts in an address, register or data byte. S_SEND_ACK drives the acknowledge. S_PUT_BYTE shifts out a read byte. S_GET_ACK samples the master's acknowledge. S_SKIP waits out a transfer that does not concern the block.

The transitions are as follows:
- START from any state enters S_GET_BYTE in address mode.
- STOP from any state enters S_IDLE.
- A completed byte enters S_SEND_ACK, or S_SKIP on an address mismatch.
- The falling SCL edge that ends S_SEND_ACK leads to S_GET_BYTE after a write, or to S_PUT_BYTE after a read.
- S_PUT_BYTE enters S_GET_ACK after eight bits.
- S_GET_ACK returns to S_PUT_BYTE on a master ACK, or enters S_SKIP on a NACK.

Top module: `i2c_accel_slave`

## Requirements
- R1: The block responds only to a 7-bit address whose upper four bits are 0010 and whose lower three bits equal `addr_sel`. Bit 0 of the address byte selects read (1) or write (0). On any other address it never drives SDA until the next START.
- R2: A matched address byte, a register address byte and each written data byte are acknowledged: SDA is held low during the 9th SCL high phase.
- R3: `sda_oe` changes only while the synchronised SCL is low, and read bytes are sent MSB first.
- R4: Writing a data byte while the register address is 0 loads its bits 3:0 into the control outputs: bit 0 `pwr_down` (1 = powered down), bit 1 `self_test`, bit 2 `bg_test`, bit 3 `temp_sel`. All four reset to 0.
- R5: A data byte written to any register address other than 0 is acknowledged, and the control outputs keep their value.
- R6: The read slots are:
  - slot 0: {4'b0000, control}
  - slot 1: X bits 15:8
  - slot 2: X bits 7:0
  - slot 3: Y bits 15:8
  - slot 4: Y bits 7:0
  - slots 5, 6 and any address above 6: 0x00
- R7: The pointer advances after every data byte, read or written. From any value of 6 or above it moves to 0.
- R8: A read begins at the register address most recently loaded, as advanced by any data bytes since then.
- R9: While `temp_sel` is 1, slots 1 and 2 return the temperature word instead of X.
- R10: Sample bits at and above position SIG_BITS (default 12) always read as 0.
- R11: The samples are captured when a read address matches. A change on the sample inputs during that read does not appear in it.
- R12: A master NACK makes the block release SDA for the rest of the transfer. A STOP returns it to idle with SDA released, and a repeated START without STOP begins a new transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| addr_sel | input | 3 | Low three bits of the slave address |
| x_word | input | 16 | X-axis sample, right-justified |
| y_word | input | 16 | Y-axis sample, right-justified |
| t_word | input | 16 | Temperature sample, right-justified |
| pwr_down | output | 1 | Control bit 0, power-down request |
| self_test | output | 1 | Control bit 1, self-test |
| bg_test | output | 1 | Control bit 2, bandgap test |
| temp_sel | output | 1 | Control bit 3, temperature in X slots |

## Verification
The assertions assume a well-behaved master. SDA changes only while SCL is low, except for START and STOP. SCL stays high or low for several system clocks. No STOP is issued while the block is pulling SDA low. The stimulus meets these conditions as follows:
- Every bus phase lasts five or more clocks.
- SDA is only ever moved while SCL is low, or while SCL is high for a deliberate START or STOP.
- Every read is ended with a NACK before its STOP.

Under these conditions, an `sda_oe` change while SCL is high, or a drive after STOP, can only come from the state machine.

// File: rtl/accel_i2c_pkg.sv
package accel_i2c_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_GET_BYTE,
        S_SEND_ACK,
        S_PUT_BYTE,
        S_GET_ACK,
        S_SKIP
    } bus_state_t;

    typedef enum logic [1:0] {
        K_ADDR,
        K_REG,
        K_DATA
    } byte_kind_t;

    localparam int WORD_W    = 16;
    localparam int CTRL_W    = 4;
    localparam int SLOT_LAST = 6;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic level,
    output logic rise,
    output logic fall
);
    // pipe[STAGES-1] is the synchronised level, pipe[STAGES] the previous one
    logic [STAGES:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= '1;
        end else begin
            pipe <= {pipe[STAGES-1:0], line_in};
        end
    end

    assign level = pipe[STAGES-1];
    assign rise  = pipe[STAGES-1] & ~pipe[STAGES];
    assign fall  = ~pipe[STAGES-1] & pipe[STAGES];

endmodule

// File: rtl/accel_regmap.sv
module accel_regmap
    import accel_i2c_pkg::*;
#(
    parameter int SIG_BITS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snap_en,
    input  logic [WORD_W-1:0] x_in,
    input  logic [WORD_W-1:0] y_in,
    input  logic [WORD_W-1:0] t_in,
    input  logic              ptr_load,
    input  logic [7:0]        ptr_val,
    input  logic              ptr_inc,
    input  logic              data_we,
    input  logic [CTRL_W-1:0] wdata,
    output logic [7:0]        rd_byte,
    output logic [7:0]        rd_ptr,
    output logic [CTRL_W-1:0] ctrl
);
    localparam logic [WORD_W-1:0] SIG_MASK = WORD_W'((64'd1 << SIG_BITS) - 64'd1);
    localparam logic [7:0]        LAST_SLOT = 8'(SLOT_LAST);

    logic [WORD_W-1:0] snap_x, snap_y, snap_t;
    logic [WORD_W-1:0] first_word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_x <= '0;
            snap_y <= '0;
            snap_t <= '0;
        end else if (snap_en) begin
            snap_x <= x_in & SIG_MASK;
            snap_y <= y_in & SIG_MASK;
            snap_t <= t_in & SIG_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
        end else if (ptr_load) begin
            rd_ptr <= ptr_val;
        end else if (ptr_inc) begin
            rd_ptr <= (rd_ptr >= LAST_SLOT) ? 8'd0 : rd_ptr + 8'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (data_we && rd_ptr == 8'd0) begin
            ctrl <= wdata;
        end
    end

    // bit 3 of the control byte swaps the temperature word into the X slots
    assign first_word = ctrl[3] ? snap_t : snap_x;

    always_comb begin
        unique case (rd_ptr)
            8'd0:    rd_byte = {{(8 - CTRL_W){1'b0}}, ctrl};
            8'd1:    rd_byte = first_word[15:8];
            8'd2:    rd_byte = first_word[7:0];
            8'd3:    rd_byte = snap_y[15:8];
            8'd4:    rd_byte = snap_y[7:0];
            default: rd_byte = 8'h00;
        endcase
    end

endmodule

// File: rtl/i2c_accel_slave.sv
module i2c_accel_slave
    import accel_i2c_pkg::*;
#(
    parameter int              DEV_ADDR_W  = 7,
    parameter int              HI_W        = 4,
    parameter logic [HI_W-1:0] ADDR_HI     = 4'b0010,
    parameter int              SYNC_STAGES = 2,
    parameter int              SIG_BITS    = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_in,
    input  logic                       sda_in,
    output logic                       sda_oe,
    input  logic [DEV_ADDR_W-HI_W-1:0] addr_sel,
    input  logic [WORD_W-1:0]          x_word,
    input  logic [WORD_W-1:0]          y_word,
    input  logic [WORD_W-1:0]          t_word,
    output logic                       pwr_down,
    output logic                       self_test,
    output logic                       bg_test,
    output logic                       temp_sel
);
    localparam logic [3:0] BYTE_BITS = 4'd8;

    logic scl_lvl, scl_rise, scl_fall;
    logic sda_lvl, sda_rise, sda_fall;
    logic start_det, stop_det;

    bus_state_t state, nxt;
    byte_kind_t kind, nxt_kind;

    logic [7:0] shreg;
    logic [7:0] txsh;
    logic [3:0] bitcnt;
    logic       reading;
    logic       mack;
    logic       byte_end;
    logic       addr_hit;

    logic              snap_en, ptr_load, ptr_inc, data_we, load_tx;
    logic [7:0]        rd_byte, rd_ptr;
    logic [CTRL_W-1:0] ctrl_q;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .line_in(scl_in),
        .level(scl_lvl), .rise(scl_rise), .fall(scl_fall)
    );

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .line_in(sda_in),
        .level(sda_lvl), .rise(sda_rise), .fall(sda_fall)
    );

    // bus conditions need SCL high on both the current and the previous sample
    assign start_det = scl_lvl & ~scl_rise & sda_fall;
    assign stop_det  = scl_lvl & ~scl_rise & sda_rise;

    assign byte_end = scl_fall && (bitcnt == BYTE_BITS);
    assign addr_hit = (shreg[7:1] == {ADDR_HI, addr_sel});

    // next state and strobes to the register map
    always_comb begin
        nxt      = state;
        nxt_kind = kind;
        snap_en  = 1'b0;
        ptr_load = 1'b0;
        ptr_inc  = 1'b0;
        data_we  = 1'b0;
        load_tx  = 1'b0;
        if (stop_det) begin
            nxt = S_IDLE;
        end else if (start_det) begin
            nxt      = S_GET_BYTE;
            nxt_kind = K_ADDR;
        end else begin
            unique case (state)
                S_IDLE, S_SKIP: begin
                    nxt = state;
                end
                S_GET_BYTE: begin
                    if (byte_end) begin
                        unique case (kind)
                            K_ADDR: begin
                                if (addr_hit) begin
                                    nxt      = S_SEND_ACK;
                                    nxt_kind = K_REG;
                                    snap_en  = shreg[0];
                                end else begin
                                    nxt = S_SKIP;
                                end
                            end
                            K_REG: begin
                                ptr_load = 1'b1;
                                nxt      = S_SEND_ACK;
                                nxt_kind = K_DATA;
                            end
                            K_DATA: begin
                                data_we = 1'b1;
                                ptr_inc = 1'b1;
                                nxt     = S_SEND_ACK;
                            end
                            default: nxt = S_SKIP;
                        endcase
                    end
                end
                S_SEND_ACK: begin
                    if (scl_fall) begin
                        if (reading) begin
                            load_tx = 1'b1;
                            ptr_inc = 1'b1;
                            nxt     = S_PUT_BYTE;
                        end else begin
                            nxt = S_GET_BYTE;
                        end
                    end
                end
                S_PUT_BYTE: begin
                    if (byte_end) begin
                        nxt = S_GET_ACK;
                    end
                end
                S_GET_ACK: begin
                    if (scl_fall) begin
                        if (mack) begin
                            load_tx = 1'b1;
                            ptr_inc = 1'b1;
                            nxt     = S_PUT_BYTE;
                        end else begin
                            nxt = S_SKIP;
                        end
                    end
                end
                default: nxt = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            kind  <= K_ADDR;
        end else begin
            state <= nxt;
            kind  <= nxt_kind;
        end
    end

    // bit datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            txsh    <= '0;
            bitcnt  <= '0;
            reading <= 1'b0;
            mack    <= 1'b0;
        end else begin
            if (start_det) begin
                bitcnt <= '0;
            end else if (state == S_GET_BYTE || state == S_PUT_BYTE) begin
                if (scl_rise) begin
                    bitcnt <= bitcnt + 4'd1;
                end
            end else begin
                bitcnt <= '0;
            end

            if (state == S_GET_BYTE && scl_rise) begin
                shreg <= {shreg[6:0], sda_lvl};
            end

            if (load_tx) begin
                txsh <= rd_byte;
            end else if (state == S_PUT_BYTE && scl_fall && bitcnt != BYTE_BITS) begin
                txsh <= {txsh[6:0], 1'b0};
            end

            if (start_det) begin
                reading <= 1'b0;
            end else if (state == S_GET_BYTE && kind == K_ADDR && byte_end) begin
                reading <= shreg[0];
            end

            if (state == S_GET_ACK && scl_rise) begin
                mack <= ~sda_lvl;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            S_SEND_ACK: sda_oe = 1'b1;
            S_PUT_BYTE: sda_oe = ~txsh[7];
            default:    sda_oe = 1'b0;
        endcase
    end

    accel_regmap #(.SIG_BITS(SIG_BITS)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .snap_en  (snap_en),
        .x_in     (x_word),
        .y_in     (y_word),
        .t_in     (t_word),
        .ptr_load (ptr_load),
        .ptr_val  (shreg),
        .ptr_inc  (ptr_inc),
        .data_we  (data_we),
        .wdata    (shreg[CTRL_W-1:0]),
        .rd_byte  (rd_byte),
        .rd_ptr   (rd_ptr),
        .ctrl     (ctrl_q)
    );

    assign pwr_down  = ctrl_q[0];
    assign self_test = ctrl_q[1];
    assign bg_test   = ctrl_q[2];
    assign temp_sel  = ctrl_q[3];

endmodule

// File: rtl/i2c_accel_slave_chk.sv
module i2c_accel_slave_chk
    import accel_i2c_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              scl_lvl,
    input logic              stop_det,
    input logic              sda_oe,
    input logic              data_we,
    input logic              ptr_inc,
    input logic              ptr_load,
    input logic [7:0]        rd_ptr,
    input logic [CTRL_W-1:0] ctrl_q
);
    localparam logic [7:0] LAST_SLOT = 8'(SLOT_LAST);

    AST_SDA_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_lvl);  // R3

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !data_we |=> $stable(ctrl_q));  // R5

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_inc && !ptr_load && rd_ptr >= LAST_SLOT) |=> (rd_ptr == 8'd0));  // R7

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_inc && !ptr_load && rd_ptr < LAST_SLOT) |=> (rd_ptr == $past(rd_ptr) + 8'd1));  // R7

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);  // R12

endmodule

bind i2c_accel_slave i2c_accel_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_lvl  (scl_lvl),
    .stop_det (stop_det),
    .sda_oe   (sda_oe),
    .data_we  (data_we),
    .ptr_inc  (ptr_inc),
    .ptr_load (ptr_load),
    .rd_ptr   (rd_ptr),
    .ctrl_q   (ctrl_q)
);

// File: tb/i2c_accel_slave_tb.sv
module i2c_accel_slave_tb;

    localparam int Q    = 5;
    localparam int SIGB = 12;
    localparam logic [15:0] MASK = 16'((32'd1 << SIGB) - 32'd1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [2:0] addr_sel = 3'd5;
    logic [15:0] x_v = 16'hF5A3;
    logic [15:0] y_v = 16'h3C7E;
    logic [15:0] t_v = 16'h9ABD;
    logic pwr_down, self_test, bg_test, temp_sel;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_accel_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
        .addr_sel(addr_sel), .x_word(x_v), .y_word(y_v), .t_word(t_v),
        .pwr_down(pwr_down), .self_test(self_test), .bg_test(bg_test), .temp_sel(temp_sel)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic i2c_start;
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic i2c_stop;
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(2 * Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        acked = ~sda_line;
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            tick(Q);
            scl_m = 1'b1; tick(Q);
            b = {b[6:0], sda_line};
            tick(Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = give_ack ? 1'b0 : 1'b1; tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] dev_w();
        return {4'b0010, addr_sel, 1'b0};
    endfunction

    function automatic logic [7:0] dev_r();
        return {4'b0010, addr_sel, 1'b1};
    endfunction

    function automatic logic [7:0] slot_val(input int s, input logic [3:0] c,
                                            input logic [15:0] x, input logic [15:0] y,
                                            input logic [15:0] t);
        logic [15:0] xm, ym;
        xm = (c[3] ? t : x) & MASK;
        ym = y & MASK;
        case (s)
            0: return {4'h0, c};
            1: return xm[15:8];
            2: return xm[7:0];
            3: return ym[15:8];
            4: return ym[7:0];
            default: return 8'h00;
        endcase
    endfunction

    function automatic int next_slot(input int s);
        return (s >= 6) ? 0 : s + 1;
    endfunction

    task automatic write_reg(input logic [7:0] r, input logic [7:0] d);
        logic ak;
        i2c_start;
        send_byte(dev_w(), ak);
        chk(ak, "R2 write address ack", 32'(ak), 32'd1);
        send_byte(r, ak);
        chk(ak, "R2 register byte ack", 32'(ak), 32'd1);
        send_byte(d, ak);
        chk(ak, "R2 data byte ack", 32'(ak), 32'd1);
        i2c_stop;
    endtask

    task automatic set_ptr(input logic [7:0] r);
        logic ak;
        i2c_start;
        send_byte(dev_w(), ak);
        chk(ak, "R2 pointer address ack", 32'(ak), 32'd1);
        send_byte(r, ak);
        chk(ak, "R2 pointer byte ack", 32'(ak), 32'd1);
        i2c_stop;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R12 act=timeout exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic ak;
        logic [7:0] b;
        logic [3:0] c;
        int s;

        tick(4);
        rst_n = 1'b1;
        tick(4);

        // reset state
        chk(sda_oe == 1'b0, "R4 reset sda_oe", 32'(sda_oe), 32'd0);
        chk({temp_sel, bg_test, self_test, pwr_down} == 4'h0, "R4 reset control",
            32'({temp_sel, bg_test, self_test, pwr_down}), 32'd0);

        // address sweep: every addr_sel against every low field and two high nibbles
        for (int a = 0; a < 8; a++) begin
            addr_sel = 3'(a);
            for (int h = 0; h < 2; h++) begin
                for (int lo = 0; lo < 8; lo++) begin
                    logic [3:0] hi;
                    hi = (h == 0) ? 4'b0010 : 4'b0110;
                    i2c_start;
                    send_byte({hi, 3'(lo), 1'b0}, ak);
                    chk(ak == ((h == 0) && (lo == a)), "R1 address match",
                        32'(ak), 32'((h == 0) && (lo == a)));
                    i2c_stop;
                end
            end
        end
        addr_sel = 3'd5;

        // R4: every control value through register 0, upper data bits set
        for (int v = 0; v < 16; v++) begin
            write_reg(8'h00, 8'hA0 | 8'(v));
            chk({temp_sel, bg_test, self_test, pwr_down} == 4'(v), "R4 control write",
                32'({temp_sel, bg_test, self_test, pwr_down}), 32'(v));
        end

        // R5: data to other registers has no effect
        write_reg(8'h00, 8'h06);
        for (int r = 1; r < 8; r++) begin
            write_reg(8'(r), 8'hFF);
            chk({temp_sel, bg_test, self_test, pwr_down} == 4'h6, "R5 ignored write",
                32'({temp_sel, bg_test, self_test, pwr_down}), 32'h6);
        end

        // R6 R7 R8 R9 R10: read sweep over start slot, temp select and two sample sets
        for (int pat = 0; pat < 2; pat++) begin
            x_v = (pat == 0) ? 16'hF5A3 : 16'h7E19;
            y_v = (pat == 0) ? 16'h3C7E : 16'hC0F4;
            t_v = (pat == 0) ? 16'h9ABD : 16'h2468;
            for (int ts = 0; ts < 2; ts++) begin
                c = {1'(ts), 3'b010};
                write_reg(8'h00, {4'h0, c});
                for (int p = 0; p < 7; p++) begin
                    set_ptr(8'(p));
                    i2c_start;
                    send_byte(dev_r(), ak);
                    chk(ak, "R2 read address ack", 32'(ak), 32'd1);
                    s = p;
                    for (int k = 0; k < 9; k++) begin
                        recv_byte(k != 8, b);
                        chk(b == slot_val(s, c, x_v, y_v, t_v),
                            "R6 R3 R7 R8 R9 R10 read byte", 32'(b),
                            32'(slot_val(s, c, x_v, y_v, t_v)));
                        s = next_slot(s);
                    end
                    i2c_stop;
                end
            end
        end

        // R7: pointer above slot 6 reads zero then wraps to slot 0
        c = 4'h3;
        write_reg(8'h00, 8'h03);
        set_ptr(8'h09);
        i2c_start;
        send_byte(dev_r(), ak);
        recv_byte(1'b1, b);
        chk(b == 8'h00, "R7 high pointer reads zero", 32'(b), 32'h0);
        recv_byte(1'b0, b);
        chk(b == 8'h03, "R7 wrap to slot 0", 32'(b), 32'h3);
        i2c_stop;

        // R8: a data write advances the pointer, so the next read starts at slot 1
        write_reg(8'h00, 8'h01);
        i2c_start;
        send_byte(dev_r(), ak);
        recv_byte(1'b0, b);
        chk(b == slot_val(1, 4'h1, x_v, y_v, t_v), "R8 read after data write",
            32'(b), 32'(slot_val(1, 4'h1, x_v, y_v, t_v)));
        i2c_stop;

        // R11: samples change after address match
        x_v = 16'h0123;
        set_ptr(8'h01);
        i2c_start;
        send_byte(dev_r(), ak);
        x_v = 16'h0FED;
        recv_byte(1'b1, b);
        chk(b == 8'h01, "R11 snapshot MSB", 32'(b), 32'h01);
        x_v = 16'h0ABC;
        recv_byte(1'b0, b);
        chk(b == 8'h23, "R11 snapshot LSB", 32'(b), 32'h23);
        i2c_stop;

        // R12: repeated start, then NACK releases the bus
        y_v = 16'h0B5C;
        i2c_start;
        send_byte(dev_w(), ak);
        send_byte(8'h03, ak);
        i2c_start;
        send_byte(dev_r(), ak);
        chk(ak, "R12 repeated start ack", 32'(ak), 32'd1);
        recv_byte(1'b0, b);
        chk(b == 8'h0B, "R12 read after repeated start", 32'(b), 32'h0B);
        recv_byte(1'b0, b);
        chk(b == 8'hFF, "R12 released after NACK", 32'(b), 32'hFF);
        i2c_stop;
        tick(Q);
        chk(sda_oe == 1'b0, "R12 idle after stop", 32'(sda_oe), 32'd0);

        // R1: a mismatched address leaves the line alone for the whole transfer
        i2c_start;
        send_byte(8'h20, ak);
        chk(!ak, "R1 mismatch no ack", 32'(ak), 32'd0);
        send_byte(8'h00, ak);
        chk(!ak, "R1 no drive after mismatch", 32'(ak), 32'd0);
        i2c_stop;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule